// File: doc/BRIEF.md
# Packed Word Palette Loader

This block is a 256-entry colour lookup table, with 8-bit red, green and blue per entry, that a host loads over a 32-bit register port. The host first writes an entry index to an address register. It then streams 32-bit words into a data register. The table is treated as one continuous byte stream: entry 0 red, entry 0 green, entry 0 blue, entry 1 red, and so on. Each word carries the next four bytes of that stream, with the most significant byte first, so the components of one entry can be split across two words. An internal pointer moves forward by four bytes on every word and wraps at the end of the table.

An entry changes only when all three of its components have arrived. Until then the lookup side keeps returning the old colour. The video path reads the table by pixel index through a separate port and gets the colour one clock later. Storage is split into four single-write banks by the low two bits of the entry index. That lets the one word in three that completes two entries commit both of them in the same cycle.

Top module: `packed_palette`

## Requirements
- R1: While `rst` is high, `pix_color` is all zeros from the clock edge after `rst` is first sampled high.
- R2: A `pix_idx` sampled at a rising edge gives that entry's colour on `pix_color` right after that edge, packed as {red[23:16], green[15:8], blue[7:0]}. One lookup can be made every cycle.
- R3: Palette bytes form one stream in which entry n has red at byte 3n, green at byte 3n+1 and blue at byte 3n+2. In a data word, bits [31:24] carry the earliest stream byte and bits [7:0] the latest.
- R4: A write to the address register sets the stream position to byte 3×(idx with its two low bits cleared). The two low bits of the index are ignored.
- R5: Each accepted data word moves the stream position forward by four bytes. Three words in a row starting at an entry that is a multiple of four fill exactly four complete entries.
- R6: The stream position wraps from byte 767 to byte 0. After blue of entry 255, the next byte is red of entry 0.
- R7: An entry whose three components have not all been written since the last address write keeps its previous colour on the lookup port.
- R8: An address write throws away any partly collected entry. The next word starts fresh at the new position, and the abandoned entry keeps its old colour.
- R9: When `addr_we` and `data_we` are both high in the same cycle, only the address write takes effect and the data word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Write strobe for the address register |
| addr_idx | input | 8 | Starting entry index (two low bits ignored) |
| data_we | input | 1 | Write strobe for the data register |
| data_word | input | 32 | Four stream bytes, earliest in bits [31:24] |
| pix_idx | input | 8 | Pixel index for lookup |
| pix_color | output | 24 | Looked-up colour {R,G,B}, one clock after `pix_idx` |

## Verification
The bench goes after the points where an entry is split across words. If the design commits an entry on its first component, a lookup after one word of a group shows a half-updated colour instead of the old one. If it keeps stale bytes after an address write, a fresh word gets spliced onto the abandoned red byte, and the wrong entry is overwritten. The wrap test loads from entry 252 and sends a fourth word: a design that misses the wrap writes nothing to entry 0 or corrupts entry 1. The index test uses an address with its low bits set: a design that does not clear them lands bytes at the wrong offset. In the collision cycle, a design that lets the data word through shifts every following entry by one group phase.

// File: rtl/packed_palette_pkg.sv
package packed_palette_pkg;
  localparam int unsigned LANES = 4;
  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_THIRD  = 2'd2
  } grp_phase_e;
endpackage

// File: rtl/pp_unpacker.sv
module pp_unpacker
  import packed_palette_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  localparam int unsigned WORD_W = LANES * COMP_W,
  localparam int unsigned RGB_W  = 3 * COMP_W,
  localparam int unsigned GRP_W  = IDX_W - 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   addr_we,
  input  logic [IDX_W-1:0]       addr_idx,
  input  logic                   data_we,
  input  logic [WORD_W-1:0]      data_word,
  output logic [LANES-1:0]       bank_we,
  output logic [GRP_W-1:0]       bank_addr,
  output logic [LANES*RGB_W-1:0] bank_data,
  output logic [GRP_W-1:0]       grp_o,
  output logic [1:0]             phase_o
);
  grp_phase_e              phase_q;
  logic [GRP_W-1:0]        grp_q;
  logic [2*COMP_W-1:0]     part_q;
  logic                    accept;

  assign accept    = data_we & ~addr_we;
  assign bank_addr = grp_q;
  assign grp_o     = grp_q;
  assign phase_o   = phase_q;

  always_comb begin
    bank_we   = '0;
    bank_data = '0;
    unique case (phase_q)
      PH_FIRST: begin
        bank_we[0] = accept;
        bank_data[0*RGB_W +: RGB_W] = data_word[WORD_W-1 -: RGB_W];
      end
      PH_SECOND: begin
        bank_we[1] = accept;
        bank_data[1*RGB_W +: RGB_W] =
          {part_q[2*COMP_W-1 -: COMP_W], data_word[WORD_W-1 -: 2*COMP_W]};
      end
      PH_THIRD: begin
        bank_we[2] = accept;
        bank_we[3] = accept;
        bank_data[2*RGB_W +: RGB_W] = {part_q, data_word[WORD_W-1 -: COMP_W]};
        bank_data[3*RGB_W +: RGB_W] = data_word[RGB_W-1:0];
      end
      default: begin
        bank_we   = '0;
        bank_data = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FIRST;
      grp_q   <= '0;
      part_q  <= '0;
    end else if (addr_we) begin
      phase_q <= PH_FIRST;
      grp_q   <= GRP_W'(addr_idx >> 2);
      part_q  <= '0;
    end else if (data_we) begin
      unique case (phase_q)
        PH_FIRST: begin
          phase_q <= PH_SECOND;
          part_q  <= {data_word[COMP_W-1:0], {COMP_W{1'b0}}};
        end
        PH_SECOND: begin
          phase_q <= PH_THIRD;
          part_q  <= data_word[2*COMP_W-1:0];
        end
        PH_THIRD: begin
          phase_q <= PH_FIRST;
          grp_q   <= grp_q + 1'b1;
          part_q  <= '0;
        end
        default: phase_q <= PH_FIRST;
      endcase
    end
  end
endmodule

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 24,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_read_select.sv
module pp_read_select
  import packed_palette_pkg::*;
#(
  parameter int unsigned RGB_W = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             lane_in,
  input  logic [LANES*RGB_W-1:0] bank_rd,
  output logic [RGB_W-1:0]       color
);
  logic [1:0] lane_q;

  always_ff @(posedge clk) begin
    if (rst) lane_q <= '0;
    else     lane_q <= lane_in;
  end

  assign color = bank_rd[lane_q*RGB_W +: RGB_W];
endmodule

// File: rtl/packed_palette.sv
module packed_palette
  import packed_palette_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  localparam int unsigned WORD_W = LANES * COMP_W,
  localparam int unsigned RGB_W  = 3 * COMP_W,
  localparam int unsigned GRP_W  = IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic [IDX_W-1:0]  addr_idx,
  input  logic              data_we,
  input  logic [WORD_W-1:0] data_word,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_color
);
  logic [LANES-1:0]       bank_we_w;
  logic [GRP_W-1:0]       bank_addr_w;
  logic [LANES*RGB_W-1:0] bank_data_w;
  logic [LANES*RGB_W-1:0] bank_rd_w;
  logic [GRP_W-1:0]       grp_w;
  logic [1:0]             phase_w;
  logic [GRP_W-1:0]       rd_row;

  assign rd_row = GRP_W'(pix_idx >> 2);

  pp_unpacker #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .addr_we   (addr_we),
    .addr_idx  (addr_idx),
    .data_we   (data_we),
    .data_word (data_word),
    .bank_we   (bank_we_w),
    .bank_addr (bank_addr_w),
    .bank_data (bank_data_w),
    .grp_o     (grp_w),
    .phase_o   (phase_w)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    pp_bank_ram #(.AW(GRP_W), .DW(RGB_W)) u_ram (
      .clk   (clk),
      .rst   (rst),
      .we    (bank_we_w[b]),
      .waddr (bank_addr_w),
      .wdata (bank_data_w[b*RGB_W +: RGB_W]),
      .raddr (rd_row),
      .rdata (bank_rd_w[b*RGB_W +: RGB_W])
    );
  end

  pp_read_select #(.RGB_W(RGB_W)) u_rsel (
    .clk     (clk),
    .rst     (rst),
    .lane_in (pix_idx[1:0]),
    .bank_rd (bank_rd_w),
    .color   (pix_color)
  );
endmodule

// File: rtl/packed_palette_chk.sv
module packed_palette_chk #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned RGB_W = 24,
  localparam int unsigned GRP_W = IDX_W - 2
) (
  input logic             clk,
  input logic             rst,
  input logic             addr_we,
  input logic [IDX_W-1:0] addr_idx,
  input logic             data_we,
  input logic [3:0]       bank_we,
  input logic [GRP_W-1:0] grp,
  input logic [1:0]       phase,
  input logic [RGB_W-1:0] pix_color
);
  p_reset_dark_r1: assert property (@(posedge clk)
    rst |=> pix_color == '0);

  p_addr_load_r4: assert property (@(posedge clk) disable iff (rst)
    addr_we |=> (grp == GRP_W'($past(addr_idx) >> 2)) && (phase == 2'd0));

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (data_we && !addr_we && phase != 2'd2) |=>
      (phase == $past(phase) + 2'd1) && (grp == $past(grp)));

  p_commit_limit_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_we) <= 2);

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (data_we && !addr_we && phase == 2'd2) |=>
      (phase == 2'd0) && (grp == GRP_W'($past(grp) + 1'b1)));

  p_no_idle_write_r7: assert property (@(posedge clk) disable iff (rst)
    !data_we |-> bank_we == 4'b0000);

  p_first_word_r7: assert property (@(posedge clk) disable iff (rst)
    (data_we && !addr_we && phase == 2'd0) |-> bank_we == 4'b0001);

  p_addr_wins_r9: assert property (@(posedge clk) disable iff (rst)
    addr_we |-> bank_we == 4'b0000);
endmodule

bind packed_palette packed_palette_chk #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr_we   (addr_we),
  .addr_idx  (addr_idx),
  .data_we   (data_we),
  .bank_we   (bank_we_w),
  .grp       (grp_w),
  .phase     (phase_w),
  .pix_color (pix_color)
);

// File: tb/packed_palette_bench.sv
`timescale 1ns/1ps
module packed_palette_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_we = 1'b0;
  logic [7:0]  addr_idx = '0;
  logic        data_we = 1'b0;
  logic [31:0] data_word = '0;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_color;

  always #4 clk = ~clk;

  packed_palette u_packed_palette (
    .clk(clk), .rst(rst), .addr_we(addr_we), .addr_idx(addr_idx),
    .data_we(data_we), .data_word(data_word), .pix_idx(pix_idx),
    .pix_color(pix_color)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [23:0] ref_pal [256];
  int          mptr = 0;
  logic [7:0]  stage [3];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        look_v = 1'b0;
  logic        pend_q = 1'b0;

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp, int idx);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s entry %0d: actual %06h expected %06h", tag, idx, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    addr_we = 1'b0; data_we = 1'b0; look_v = 1'b0;
  endtask

  task automatic model_addr(logic [7:0] idx);
    mptr = 3 * int'(idx & 8'hFC);
  endtask

  task automatic wr_addr(logic [7:0] idx);
    @(negedge clk);
    addr_we = 1'b1; addr_idx = idx; data_we = 1'b0; look_v = 1'b0;
    model_addr(idx);
  endtask

  task automatic wr_word(logic [31:0] w);
    @(negedge clk);
    addr_we = 1'b0; data_we = 1'b1; data_word = w; look_v = 1'b0;
    for (int k = 0; k < 4; k++) begin
      stage[mptr % 3] = w[31 - 8*k -: 8];
      if (mptr % 3 == 2) ref_pal[mptr / 3] = {stage[0], stage[1], stage[2]};
      mptr = (mptr + 1) % 768;
    end
  endtask

  task automatic wr_both(logic [7:0] idx, logic [31:0] w);
    @(negedge clk);
    addr_we = 1'b1; addr_idx = idx; data_we = 1'b1; data_word = w; look_v = 1'b0;
    model_addr(idx);
  endtask

  task automatic lookup(string tag, int idx);
    @(negedge clk);
    addr_we = 1'b0; data_we = 1'b0;
    pix_idx = 8'(idx); look_v = 1'b1;
    exp_q.push_back({8'(idx), ref_pal[idx]});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) pend_q <= look_v;

  always @(negedge clk) begin
    if (pend_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pix_color, e[23:0], int'(e[31:24]));
    end
  end

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 37 + s) & 255);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_pal[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset output", pix_color, 24'h0, 0);
    @(negedge clk);
    rst = 1'b0;

    // R3 R5 R2: whole table from entry 0, then back-to-back lookups
    wr_addr(8'd0);
    for (int j = 0; j < 192; j++)
      wr_word({pat(4*j, 11), pat(4*j+1, 11), pat(4*j+2, 11), pat(4*j+3, 11)});
    idle();
    for (int i = 0; i < 256; i++) lookup("R3 stream order", i);
    lookup("R2 latency repeat", 17);
    lookup("R2 latency repeat", 200);
    idle(); idle();

    // R4: low index bits ignored
    wr_addr(8'd6);
    wr_word(32'hA1A2A3A4); wr_word(32'hA5A6A7A8); wr_word(32'hA9AAABAC);
    idle();
    for (int i = 3; i <= 8; i++) lookup("R4 index rounding", i);
    idle(); idle();

    // R7: partial entries hold old colour
    wr_addr(8'd8);
    wr_word(32'h11223344); idle();
    lookup("R7 first word done", 8); lookup("R7 partial hold", 9); idle(); idle();
    wr_word(32'h55667788); idle();
    lookup("R7 second word done", 9); lookup("R7 partial hold", 10); idle(); idle();
    wr_word(32'h99AABBCC); idle();
    lookup("R5 group complete", 10); lookup("R5 group complete", 11); idle(); idle();

    // R8: address write drops partial entry
    wr_addr(8'd12); wr_word(32'hDE0102EF);
    wr_addr(8'd12); wr_word(32'h0A0B0C0D);
    idle();
    lookup("R8 restart entry", 12); lookup("R8 abandoned entry", 13);
    lookup("R8 abandoned entry", 14);
    idle(); idle();

    // R6: wrap from entry 255 to entry 0
    wr_addr(8'd252);
    wr_word(32'hC0C1C2C3); wr_word(32'hC4C5C6C7);
    wr_word(32'hC8C9CACB); wr_word(32'hCCCDCECF);
    idle();
    for (int i = 252; i < 256; i++) lookup("R6 tail group", i);
    lookup("R6 wrapped entry", 0); lookup("R6 partial after wrap", 1);
    idle(); idle();

    // R9: address and data in the same cycle
    wr_both(8'd32, 32'hEEEEEEEE);
    wr_word(32'h31323334);
    idle();
    lookup("R9 data dropped", 32); lookup("R9 data dropped", 33);
    lookup("R9 neighbour", 31);
    idle(); idle();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule